// File: doc/BRIEF.md
# Authenticated Return Stack Controller

This block keeps the return stack of a secure core whose instructions are chained by keys. When a call executes, the core hands over the address of the call and a fresh random key. The block forms the return address (one past the call), pairs it with that key, asks an external keyed-MAC engine for a tag over the pair, and stores address, key and tag together in a 16-entry internal stack. When a return executes, the block reads the top entry, sends the stored address and key back to the MAC engine, and compares the fresh tag with the stored one. On a match it delivers the address as the next instruction pointer and the key as the key that encrypts the registers for the next instruction. On a mismatch it stops.

Every request is acknowledged only after the MAC engine answers, and only one operation is in flight at a time. Pushing onto a full stack, popping an empty one, or a tag mismatch each record a fault code and put the block into a halted state. The halted state lasts until reset and ignores all further requests. The requester holds a request level until `done` or `halt`.

Top module: `ret_stack_guard`

## Requirements
- R1: After reset `halt`, `done` and `mac_req` are 0, `fault` is 0, and `ret_ip` and `ret_key` are 0.
- R2: On a push the message sent to the MAC engine is {call_ip + 1, fresh_key}, with the address in the upper AW bits. `mac_req` and `mac_msg` stay unchanged until `mac_ack` is seen.
- R3: `done` pulses for one cycle, in the cycle after the cycle in which `mac_ack` is high. No operation completes without a MAC response. With a MAC latency of 3 cycles, a request raised in one cycle sees `done` four cycles later.
- R4: Pops return entries in last-in, first-out order. On a matching tag `ret_ip` takes the stored return address and `ret_key` takes the stored key, and both hold until the next successful pop.
- R5: On a pop the message sent to the MAC engine is the stored {return address, key} of the top entry.
- R6: If the tag from the MAC engine differs from the stored tag on a pop, the block halts with `fault` = 3, gives no `done`, and leaves `ret_ip` and `ret_key` unchanged.
- R7: A push while 16 entries are stored halts the block with `fault` = 1 and issues no MAC request.
- R8: A pop while the stack is empty halts the block with `fault` = 2 and issues no MAC request.
- R9: Once halted, the block stays halted, keeps its fault code, and ignores push and pop requests (no `mac_req`, no `done`) until reset.
- R10: If push and pop are both requested while the block is idle, the push is served first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| push_req | input | 1 | Call request, held until done or halt |
| call_ip | input | AW | Address of the call instruction |
| fresh_key | input | KW | Random return key for this call |
| pop_req | input | 1 | Return request, held until done or halt |
| done | output | 1 | One-cycle completion pulse |
| ret_ip | output | AW | Instruction pointer restored by the last successful pop |
| ret_key | output | KW | Register-encryption key restored by the last successful pop |
| halt | output | 1 | Block has stopped on a fault |
| fault | output | 2 | 0 none, 1 push when full, 2 pop when empty, 3 tag mismatch |
| mac_req | output | 1 | Request to the MAC engine |
| mac_msg | output | AW+KW | Message to be tagged: {address, key} |
| mac_ack | input | 1 | MAC engine response strobe |
| mac_tag | input | TW | Tag returned with mac_ack |

## Verification
The assertions check on every cycle the rules that hold in any history. A fault always comes with a halt. A halt never clears and suppresses all MAC traffic and completions. A pending MAC request keeps its message stable. A completion always follows a MAC response. What the assertions cannot show is the data behaviour: the exact message formed for a push and for a pop, the LIFO order of the returned pairs, the boundaries at 16 entries and at empty, the refusal to update the outputs on a forged tag, and the push-first choice on a double request. The bench covers these with a reference stack and a MAC model that can be made to tamper.

// File: rtl/rstk_pkg.sv
package rstk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PUSH = 2'd1,
    ST_POP  = 2'd2,
    ST_HALT = 2'd3
  } rstk_state_e;

  // Fault codes visible on the fault port.
  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_FULL  = 2'd1,
    FLT_EMPTY = 2'd2,
    FLT_TAG   = 2'd3
  } rstk_fault_e;

endpackage

// File: rtl/rstk_ptr.sv
// Stack pointer: counts stored entries, flags the two boundaries.
module rstk_ptr #(
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  output logic [IW-1:0] wr_idx,
  output logic [IW-1:0] top_idx,
  output logic          full,
  output logic          empty
);

  logic [CW-1:0] sp_q, sp_d;
  logic          sp_en;
  logic [CW-1:0] sp_m1;

  assign sp_en = inc ^ dec;

  always_comb begin
    sp_d = sp_q;
    if (inc)      sp_d = sp_q + CW'(1);
    else if (dec) sp_d = sp_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp_q <= '0;
    else if (sp_en) sp_q <= sp_d;
  end

  assign sp_m1   = sp_q - CW'(1);
  assign wr_idx  = sp_q[IW-1:0];
  assign top_idx = sp_m1[IW-1:0];
  assign full    = (sp_q == CW'(DEPTH));
  assign empty   = (sp_q == '0);

endmodule

// File: rtl/rstk_store.sv
// Entry storage: one write port, one asynchronous read port.
module rstk_store #(
  parameter int DEPTH = 16,
  parameter int EW    = 128,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [EW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [EW-1:0] rd_data
);

  logic [EW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign rd_data = mem[rd_idx];

endmodule

// File: rtl/ret_stack_guard.sv
module ret_stack_guard
  import rstk_pkg::*;
#(
  parameter int AW    = 32,
  parameter int KW    = 64,
  parameter int TW    = 32,
  parameter int DEPTH = 16,
  localparam int MW = AW + KW,
  localparam int EW = MW + TW,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic [AW-1:0] call_ip,
  input  logic [KW-1:0] fresh_key,
  input  logic          pop_req,
  output logic          done,
  output logic [AW-1:0] ret_ip,
  output logic [KW-1:0] ret_key,
  output logic          halt,
  output logic [1:0]    fault,
  output logic          mac_req,
  output logic [MW-1:0] mac_msg,
  input  logic          mac_ack,
  input  logic [TW-1:0] mac_tag
);

  // Reset: asserted asynchronously, released after two clocks.
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  rstk_state_e   state_q, state_d;
  rstk_fault_e   fault_q, fault_d;
  logic [MW-1:0] msg_q, msg_d;
  logic [TW-1:0] tag_q, tag_d;
  logic [MW-1:0] ret_q, ret_d;
  logic          done_q, done_d;
  logic          msg_en, ret_en, fault_en;

  logic          ptr_inc, ptr_dec, st_full, st_empty;
  logic [IW-1:0] wr_idx, top_idx;
  logic          wr_en;
  logic [EW-1:0] rd_data;

  rstk_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_ni),
    .inc     (ptr_inc),
    .dec     (ptr_dec),
    .wr_idx  (wr_idx),
    .top_idx (top_idx),
    .full    (st_full),
    .empty   (st_empty)
  );

  rstk_store #(.DEPTH(DEPTH), .EW(EW)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data ({msg_q, mac_tag}),
    .rd_idx  (top_idx),
    .rd_data (rd_data)
  );

  // Next-state logic.
  always_comb begin
    state_d  = state_q;
    fault_d  = fault_q;
    msg_d    = msg_q;
    tag_d    = tag_q;
    ret_d    = ret_q;
    done_d   = 1'b0;
    msg_en   = 1'b0;
    ret_en   = 1'b0;
    fault_en = 1'b0;
    ptr_inc  = 1'b0;
    ptr_dec  = 1'b0;
    wr_en    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (push_req) begin
          if (st_full) begin
            fault_d  = FLT_FULL;
            fault_en = 1'b1;
            state_d  = ST_HALT;
          end else begin
            msg_d   = {call_ip + AW'(1), fresh_key};
            msg_en  = 1'b1;
            state_d = ST_PUSH;
          end
        end else if (pop_req) begin
          if (st_empty) begin
            fault_d  = FLT_EMPTY;
            fault_en = 1'b1;
            state_d  = ST_HALT;
          end else begin
            msg_d   = rd_data[EW-1:TW];
            tag_d   = rd_data[TW-1:0];
            msg_en  = 1'b1;
            state_d = ST_POP;
          end
        end
      end
      ST_PUSH: begin
        if (mac_ack) begin
          wr_en   = 1'b1;
          ptr_inc = 1'b1;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_POP: begin
        if (mac_ack) begin
          if (mac_tag == tag_q) begin
            ptr_dec = 1'b1;
            ret_d   = msg_q;
            ret_en  = 1'b1;
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            fault_d  = FLT_TAG;
            fault_en = 1'b1;
            state_d  = ST_HALT;
          end
        end
      end
      default: state_d = ST_HALT;
    endcase
  end

  // Registers.
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      fault_q <= FLT_NONE;
      done_q  <= 1'b0;
      ret_q   <= '0;
      msg_q   <= '0;
      tag_q   <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (fault_en) fault_q <= fault_d;
      if (ret_en)   ret_q   <= ret_d;
      if (msg_en) begin
        msg_q <= msg_d;
        tag_q <= tag_d;
      end
    end
  end

  assign done    = done_q;
  assign ret_ip  = ret_q[MW-1:KW];
  assign ret_key = ret_q[KW-1:0];
  assign halt    = (state_q == ST_HALT);
  assign fault   = fault_q;
  assign mac_req = (state_q == ST_PUSH) || (state_q == ST_POP);
  assign mac_msg = msg_q;

endmodule

// File: rtl/ret_stack_guard_chk.sv
module ret_stack_guard_chk #(
  parameter int AW = 32,
  parameter int KW = 64,
  parameter int TW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          done,
  input logic          halt,
  input logic [1:0]    fault,
  input logic          mac_req,
  input logic [AW+KW-1:0] mac_msg,
  input logic          mac_ack
);

  // R2: a pending MAC request holds its message until answered.
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_req && !mac_ack) |=> (mac_req && $stable(mac_msg)));

  // R3: completion only right after a MAC response.
  p_done_after_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mac_ack));

  // R6, R7, R8: every fault code comes with a halt.
  p_fault_halts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fault != 2'd0) |-> halt);

  // R9: halt is sticky and keeps its fault code.
  p_halt_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (halt && $stable(fault)));

  // R9: no MAC traffic and no completion while halted.
  p_halt_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> (!mac_req && !done));

endmodule

bind ret_stack_guard ret_stack_guard_chk #(.AW(AW), .KW(KW), .TW(TW)) u_chk (.*);

// File: tb/ret_stack_guard_test.sv
module ret_stack_guard_test;

  localparam int AW = 32;
  localparam int KW = 64;
  localparam int TW = 32;
  localparam int MW = AW + KW;
  localparam int DEPTH = 16;
  localparam int LAT = 3;
  localparam int NV = 8;

  // Vector: {is_pop, call_ip, key}
  localparam logic [MW:0] VEC [NV] = '{
    {1'b0, 32'h0000_1000, 64'h1111_2222_3333_4444},
    {1'b0, 32'h0000_2040, 64'hDEAD_BEEF_0BAD_F00D},
    {1'b1, 32'h0,         64'h0},
    {1'b0, 32'hFFFF_FFFF, 64'h0123_4567_89AB_CDEF},
    {1'b1, 32'h0,         64'h0},
    {1'b1, 32'h0,         64'h0},
    {1'b0, 32'h0000_0007, 64'hFFFF_0000_FFFF_0000},
    {1'b1, 32'h0,         64'h0}
  };

  logic          clk, rst_n;
  logic          push_req, pop_req;
  logic [AW-1:0] call_ip;
  logic [KW-1:0] fresh_key;
  logic          done, halt, mac_req, mac_ack;
  logic [AW-1:0] ret_ip;
  logic [KW-1:0] ret_key;
  logic [1:0]    fault;
  logic [MW-1:0] mac_msg;
  logic [TW-1:0] mac_tag;

  int n_chk, n_fail;
  int mac_cnt, mac_seen;
  bit tamper;
  logic [MW-1:0] last_msg;
  logic [MW-1:0] ref_stk [DEPTH];
  int ref_sp;

  ret_stack_guard uut (
    .clk(clk), .rst_n(rst_n), .push_req(push_req), .call_ip(call_ip),
    .fresh_key(fresh_key), .pop_req(pop_req), .done(done), .ret_ip(ret_ip),
    .ret_key(ret_key), .halt(halt), .fault(fault), .mac_req(mac_req),
    .mac_msg(mac_msg), .mac_ack(mac_ack), .mac_tag(mac_tag)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [TW-1:0] ref_tag(input logic [MW-1:0] m);
    return m[31:0] ^ m[63:32] ^ m[95:64] ^ 32'hA5C3_0F96;
  endfunction

  // MAC engine model: answers after LAT cycles of a held request.
  always @(negedge clk) begin
    if (mac_req) begin
      mac_seen <= mac_seen + 1;
      if (mac_cnt + 1 == LAT) begin
        mac_ack  <= 1'b1;
        mac_tag  <= ref_tag(mac_msg) ^ {31'b0, tamper};
        last_msg <= mac_msg;
      end else begin
        mac_ack <= 1'b0;
      end
      mac_cnt <= mac_cnt + 1;
    end else begin
      mac_cnt <= 0;
      mac_ack <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; push_req = 1'b0; pop_req = 1'b0; tamper = 1'b0;
    call_ip = '0; fresh_key = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    ref_sp = 0;
  endtask

  // Drive a request at a negedge, wait for done or halt, drop it.
  task automatic run_op(input bit psh, input bit pp, input logic [AW-1:0] ip,
                        input logic [KW-1:0] key, output int cyc);
    push_req = psh; pop_req = pp; call_ip = ip; fresh_key = key;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!done && !halt && cyc < 40);
    push_req = 1'b0; pop_req = 1'b0;
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cyc;
    n_chk = 0; n_fail = 0; mac_cnt = 0; mac_seen = 0; mac_ack = 1'b0;
    mac_tag = '0; last_msg = '0;
    do_reset();

    // R1: reset state.
    chk(!halt && !done && !mac_req, "R1 flags", {halt, done, mac_req}, 0);
    chk(fault == 2'd0, "R1 fault", fault, 0);
    chk(ret_ip == '0 && ret_key == '0, "R1 outputs", {ret_ip, ret_key}, 0);

    // Table walk: pushes and pops against a reference stack.
    for (int i = 0; i < NV; i++) begin
      logic [MW:0] v;
      v = VEC[i];
      if (!v[MW]) begin
        logic [MW-1:0] exp;
        exp = {v[MW-1:KW] + AW'(1), v[KW-1:0]};
        run_op(1'b1, 1'b0, v[MW-1:KW], v[KW-1:0], cyc);
        chk(done && cyc == LAT + 1, "R3 push latency", cyc, LAT + 1);
        chk(last_msg == exp, "R2 push message", last_msg, exp);
        ref_stk[ref_sp] = exp;
        ref_sp++;
      end else begin
        logic [MW-1:0] exp;
        ref_sp--;
        exp = ref_stk[ref_sp];
        run_op(1'b0, 1'b1, '0, '0, cyc);
        chk(done && cyc == LAT + 1, "R3 pop latency", cyc, LAT + 1);
        chk(last_msg == exp, "R5 pop message", last_msg, exp);
        chk({ret_ip, ret_key} == exp, "R4 LIFO return", {ret_ip, ret_key}, exp);
      end
      @(negedge clk);
      chk(!done, "R3 single pulse", done, 0);
    end

    // R7 and R9: fill, overflow, then requests ignored.
    do_reset();
    for (int i = 0; i < DEPTH; i++) begin
      run_op(1'b1, 1'b0, AW'(i * 4), KW'(i) ^ 64'h55AA, cyc);
      chk(done && !halt, "R7 fill push", {done, halt}, 2'b10);
    end
    mac_seen = 0;
    run_op(1'b1, 1'b0, 32'h9999, 64'h1, cyc);
    chk(halt && fault == 2'd1, "R7 overflow fault", fault, 1);
    chk(mac_seen == 0, "R7 no MAC on overflow", mac_seen, 0);
    push_req = 1'b1; pop_req = 1'b1;
    begin
      int dn;
      dn = 0;
      repeat (8) begin
        @(negedge clk);
        if (done) dn++;
      end
      push_req = 1'b0; pop_req = 1'b0;
      chk(dn == 0 && mac_seen == 0, "R9 ignored after halt", {dn, mac_seen}, 0);
    end
    chk(halt && fault == 2'd1, "R9 halt kept", fault, 1);

    // R8: pop when empty.
    do_reset();
    chk(!halt && fault == 2'd0, "R1 reset clears halt", fault, 0);
    mac_seen = 0;
    run_op(1'b0, 1'b1, '0, '0, cyc);
    chk(halt && fault == 2'd2, "R8 underflow fault", fault, 2);
    chk(mac_seen == 0, "R8 no MAC on underflow", mac_seen, 0);

    // R6: forged tag on pop.
    do_reset();
    run_op(1'b1, 1'b0, 32'h400, 64'hCAFE, cyc);
    run_op(1'b1, 1'b0, 32'h800, 64'hBEEF, cyc);
    run_op(1'b0, 1'b1, '0, '0, cyc);
    chk(ret_ip == 32'h801 && ret_key == 64'hBEEF, "R4 good pop", ret_ip, 32'h801);
    tamper = 1'b1;
    run_op(1'b0, 1'b1, '0, '0, cyc);
    chk(halt && fault == 2'd3 && !done, "R6 tag fault", fault, 3);
    chk(ret_ip == 32'h801 && ret_key == 64'hBEEF, "R6 outputs kept",
        {ret_ip, ret_key}, {32'h801, 64'hBEEF});
    tamper = 1'b0;

    // R10: both requests while empty: push first, then pop succeeds.
    do_reset();
    push_req = 1'b1; pop_req = 1'b1; call_ip = 32'h123; fresh_key = 64'h77;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!done && !halt && cyc < 40);
    push_req = 1'b0;
    chk(done && !halt, "R10 push first", {done, halt}, 2'b10);
    chk(last_msg == {32'h124, 64'h77}, "R10 push message", last_msg, {32'h124, 64'h77});
    run_op(1'b0, 1'b1, '0, '0, cyc);
    chk(done && ret_ip == 32'h124 && ret_key == 64'h77, "R10 pop after",
        ret_ip, 32'h124);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule